// File: doc/BRIEF.md
# Pseudo-Noise Shift-Register Generator

This block is a 16-bit linear-feedback shift register in the external-XOR (many-to-one) arrangement. On each enabled clock it shifts its state one place toward the output end. It takes the parity of the tapped bits and writes it into the vacated bit at the far end. The bit at the output end is the serial pseudo-noise stream. The full state is also visible in parallel.

A run-time input selects plain parity or inverted parity (XNOR) as the feedback. The XNOR mode walks the bitwise complement of the XOR-mode sequence. Its forbidden state is all ones rather than all zeros, so a register cleared to zero runs with no seed. The block flags the forbidden state of the current mode. It never stays in that state: a forbidden seed, or a step taken from a forbidden state, loads a legal recovery constant and sets a sticky flag.

The tap set is a compile-time mask. A second parameter swaps the mask for its mirrored counterpart.

Top module: `lfsr_pn_gen`

## Requirements
- R1: While `rst_n` is low, a clock edge sets `state_out` to 16'h0001 if `xnor_mode` is 0 and to 16'h0000 if `xnor_mode` is 1. The same edge clears `lockup_seen`.
- R2: A step happens when `step_en` is 1, `seed_load` is 0 and the state is legal. It makes the new state equal to {fb, old[15:1]}, where fb is the XOR of old[i] over every set bit i of the tap mask, inverted when `xnor_mode` is 1. State bit index = 16 − tap position, with position 1 at the input end. The default mask is 16'h002D, which is taps 16, 14, 13 and 11.
- R3: `pn_bit` always equals `state_out[0]`, the output-end bit.
- R4: In XNOR mode, starting from the complement of a seed, every state is the bitwise complement of the matching XOR-mode state. From the all-zero state, XNOR mode runs without a seed.
- R5: With `step_en` and `seed_load` both 0, the state holds whatever `seed_value` does.
- R6: When `seed_load` is 1 and the seed is legal, the next state is `seed_value`. This holds whatever `step_en` is.
- R7: Loading the forbidden seed of the current mode has a fixed result. In XOR mode that seed is 16'h0000 and the block loads 16'h0001. In XNOR mode it is 16'hFFFF and the block loads 16'h0000. In both cases `lockup_seen` becomes 1 and stays 1 until reset.
- R8: `lockup_now` is 1 in the same cycle as the state equals the forbidden value of the current mode. This holds even when the mode has just changed and no step has been taken.
- R9: A step taken from a forbidden state loads the recovery constant of R7 and sets `lockup_seen`. No load or step ever leaves a forbidden state behind.
- R10: With the default mask, starting from seed 16'h8001, the seed returns first after exactly 65535 steps.
- R11: With the mask 16'h100B (taps 16, 15, 13, 4), the sequence follows R2, and seed 16'h8001 returns first after 65535 steps.
- R12: With the mirror option set, the default taps k become 16 − k, giving the mask 16'h6801. The sequence follows R2 with that mask and has period 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Advance the register one step |
| xnor_mode | input | 1 | 0: XOR feedback, 1: XNOR feedback |
| seed_load | input | 1 | Replace the state with `seed_value` |
| seed_value | input | 16 | Seed to load |
| pn_bit | output | 1 | Serial pseudo-noise output |
| state_out | output | 16 | Parallel view of the state |
| lockup_now | output | 1 | State is forbidden for the current mode |
| lockup_seen | output | 1 | Sticky: a recovery has happened since reset |

## Verification
Reset, seed loads, steps and recoveries all show on `state_out`, `pn_bit` and `lockup_seen` one clock edge after the inputs that cause them. `lockup_now` follows the state and the mode in the same cycle. The driver changes inputs on the falling edge and queues the value it expects after the next rising edge. The monitor pops that entry 1 ns after the rising edge, so every comparison lands in the cycle where the result is due. Periods are counted as steps until the seed returns. Because the update is a bijection when the output-end bit is tapped, a first return at step 65535 also rules out any earlier repeat.

// File: rtl/lfsr_pn_pkg.sv
// Shared types for the pseudo-noise shift-register generator.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package lfsr_pn_pkg;

    // Feedback polarity applied to the tap parity.
    typedef enum logic {
        FB_XOR  = 1'b0,
        FB_XNOR = 1'b1
    } fb_mode_e;

endpackage

// File: rtl/lfsr_tap_parity.sv
// Feedback bit of a many-to-one shift register: the parity of the
// tapped state bits, inverted in XNOR mode.
// Assumes: TAPS[0] is set, so the output-end bit is always a tap.
module lfsr_tap_parity
    import lfsr_pn_pkg::*;
#(
    parameter int              WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS  = 16'h002D
) (
    input  logic [WIDTH-1:0] state_in,
    input  fb_mode_e         mode,
    output logic             feedback
);

    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] gated;

    // The chain starts at the mode bit, so XNOR comes out as inverted parity.
    assign chain[0] = (mode == FB_XNOR);

    // One gated term and one XOR stage per state bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        assign gated[i]   = state_in[i] & TAPS[i];
        assign chain[i+1] = chain[i] ^ gated[i];
    end

    assign feedback = chain[WIDTH];

endmodule

// File: rtl/lfsr_lock_detect.sv
// Flags a vector equal to the forbidden state of the feedback mode:
// all zeros in XOR mode, all ones in XNOR mode.
// Assumes: pure combinational logic, used for both the state and the seed.
module lfsr_lock_detect
    import lfsr_pn_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] vec,
    input  fb_mode_e         mode,
    output logic             forbidden
);

    // Compare against the forbidden pattern of the selected mode.
    always_comb begin
        if (mode == FB_XNOR) forbidden = &vec;
        else                 forbidden = ~|vec;
    end

endmodule

// File: rtl/lfsr_state_core.sv
// State register with reset, seed load, step and lock-up recovery.
// Priority: reset, then seed load, then step.
// A forbidden seed, or a step from a forbidden state, loads the
// recovery constant of the mode and sets the sticky flag.
// Assumes: feedback and the forbidden flags come from the current
// state, seed and mode.
module lfsr_state_core
    import lfsr_pn_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             seed_load,
    input  fb_mode_e         mode,
    input  logic [WIDTH-1:0] seed_value,
    input  logic             feedback,
    input  logic             state_bad,
    input  logic             seed_bad,
    output logic [WIDTH-1:0] state_q,
    output logic             seen_q
);

    localparam logic [WIDTH-1:0] ONE_HOT_LOW = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] recover_val;

    // Legal restart value of each mode; it is also the reset value.
    always_comb begin
        recover_val = (mode == FB_XNOR) ? '0 : ONE_HOT_LOW;
    end

    // State and sticky lock-up flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= recover_val;
            seen_q  <= 1'b0;
        end else if (seed_load) begin
            if (seed_bad) begin
                state_q <= recover_val;
                seen_q  <= 1'b1;
            end else begin
                state_q <= seed_value;
            end
        end else if (step_en) begin
            if (state_bad) begin
                state_q <= recover_val;
                seen_q  <= 1'b1;
            end else begin
                state_q <= {feedback, state_q[WIDTH-1:1]};
            end
        end
    end

endmodule

// File: rtl/lfsr_pn_gen.sv
// Pseudo-noise generator: a many-to-one shift register with run-time
// XOR/XNOR feedback, seeding, and lock-up detection and recovery.
// Assumes: TAP_MASK[0] is set. MIRROR=1 swaps in the mirrored tap set.
// State bit index i holds tap position WIDTH-i.
module lfsr_pn_gen
    import lfsr_pn_pkg::*;
#(
    parameter int               WIDTH    = 16,
    parameter logic [WIDTH-1:0] TAP_MASK = 16'h002D,
    parameter bit               MIRROR   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             xnor_mode,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed_value,
    output logic             pn_bit,
    output logic [WIDTH-1:0] state_out,
    output logic             lockup_now,
    output logic             lockup_seen
);

    // Mirror: index 0 stays, index i (tap WIDTH-i) moves to index WIDTH-i.
    function automatic logic [WIDTH-1:0] mirror_taps(input logic [WIDTH-1:0] m);
        logic [WIDTH-1:0] r;
        r    = '0;
        r[0] = m[0];
        for (int i = 1; i < WIDTH; i++) r[WIDTH-i] = m[i];
        return r;
    endfunction

    localparam logic [WIDTH-1:0] USED_TAPS = MIRROR ? mirror_taps(TAP_MASK) : TAP_MASK;

    fb_mode_e         mode;
    logic [WIDTH-1:0] state_q;
    logic             fb_bit;
    logic             state_bad;
    logic             seed_bad;
    logic             seen_q;

    assign mode = fb_mode_e'(xnor_mode);

    lfsr_tap_parity #(.WIDTH(WIDTH), .TAPS(USED_TAPS)) u_parity (
        .state_in (state_q),
        .mode     (mode),
        .feedback (fb_bit)
    );

    lfsr_lock_detect #(.WIDTH(WIDTH)) u_state_chk (
        .vec       (state_q),
        .mode      (mode),
        .forbidden (state_bad)
    );

    lfsr_lock_detect #(.WIDTH(WIDTH)) u_seed_chk (
        .vec       (seed_value),
        .mode      (mode),
        .forbidden (seed_bad)
    );

    lfsr_state_core #(.WIDTH(WIDTH)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .seed_load  (seed_load),
        .mode       (mode),
        .seed_value (seed_value),
        .feedback   (fb_bit),
        .state_bad  (state_bad),
        .seed_bad   (seed_bad),
        .state_q    (state_q),
        .seen_q     (seen_q)
    );

    assign state_out   = state_q;
    assign pn_bit      = state_q[0];
    assign lockup_now  = state_bad;
    assign lockup_seen = seen_q;

endmodule

// File: rtl/lfsr_pn_gen_checker.sv
// Temporal properties of the pseudo-noise generator, attached by bind.
// Assumes: the same clock and active-low reset as the generator.
module lfsr_pn_gen_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_en,
    input logic             xnor_mode,
    input logic             seed_load,
    input logic [WIDTH-1:0] seed_value,
    input logic [WIDTH-1:0] state_out,
    input logic             lockup_seen
);

    localparam logic [WIDTH-1:0] ONE_LOW = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] bad_pat;
    assign bad_pat = xnor_mode ? '1 : '0;

    // No load and no step leaves the register in a forbidden state.
    assert_no_lockup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load || step_en) |=> (state_out != ($past(xnor_mode) ? '1 : '0)));

    // With neither load nor step, the state holds.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !step_en) |=> $stable(state_out));

    // A legal seed appears one cycle later.
    assert_seed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && seed_value != bad_pat) |=> (state_out == $past(seed_value)));

    // A forbidden seed loads the recovery constant and sets the flag.
    assert_bad_seed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && seed_value == bad_pat) |=>
        (lockup_seen && state_out == ($past(xnor_mode) ? '0 : ONE_LOW)));

    // The lock-up flag is sticky until reset.
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lockup_seen |=> lockup_seen);

    // A legal step shifts every bit one place toward the output end.
    assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !seed_load && state_out != bad_pat) |=>
        (state_out[WIDTH-2:0] == $past(state_out[WIDTH-1:1])));

endmodule

bind lfsr_pn_gen lfsr_pn_gen_checker #(.WIDTH(WIDTH)) u_lfsr_pn_gen_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_en     (step_en),
    .xnor_mode   (xnor_mode),
    .seed_load   (seed_load),
    .seed_value  (seed_value),
    .state_out   (state_out),
    .lockup_seen (lockup_seen)
);

// File: tb/lfsr_pn_gen_bench.sv
`timescale 1ns/1ps
// Scoreboard bench for the pseudo-noise generator and two tap variants.
module lfsr_pn_gen_bench;

    typedef struct {
        logic [15:0] st;
        logic        seen;
        logic        lock;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        xnor_mode = 1'b0;
    logic        seed_load = 1'b0;
    logic [15:0] seed_value = 16'h0000;

    logic        pn_bit, lockup_now, lockup_seen;
    logic [15:0] state_out;
    logic        a_pn, a_now, a_seen;
    logic [15:0] a_state;
    logic        m_pn, m_now, m_seen;
    logic [15:0] m_state;

    int errors = 0;
    int checks = 0;
    exp_t sbq[$];

    // Model state of the main instance.
    logic [15:0] mdl_st;
    logic        mdl_seen;
    logic [15:0] xs [0:20];

    always #2 clk = ~clk;

    lfsr_pn_gen u_lfsr_pn_gen (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .xnor_mode(xnor_mode),
        .seed_load(seed_load), .seed_value(seed_value), .pn_bit(pn_bit),
        .state_out(state_out), .lockup_now(lockup_now), .lockup_seen(lockup_seen)
    );

    lfsr_pn_gen #(.TAP_MASK(16'h100B)) u_lfsr_pn_gen_alt (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .xnor_mode(xnor_mode),
        .seed_load(seed_load), .seed_value(seed_value), .pn_bit(a_pn),
        .state_out(a_state), .lockup_now(a_now), .lockup_seen(a_seen)
    );

    lfsr_pn_gen #(.MIRROR(1'b1)) u_lfsr_pn_gen_mir (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .xnor_mode(xnor_mode),
        .seed_load(seed_load), .seed_value(seed_value), .pn_bit(m_pn),
        .state_out(m_state), .lockup_now(m_now), .lockup_seen(m_seen)
    );

    function automatic logic [15:0] bad_of(input logic mode);
        return mode ? 16'hFFFF : 16'h0000;
    endfunction

    function automatic logic [15:0] rec_of(input logic mode);
        return mode ? 16'h0000 : 16'h0001;
    endfunction

    // One step as R2 states it.
    function automatic logic [15:0] ref_step(input logic [15:0] s, input logic mode,
                                             input logic [15:0] mask);
        logic fb;
        fb = mode;
        for (int i = 0; i < 16; i++) if (mask[i]) fb = fb ^ s[i];
        return {fb, s[15:1]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: apply one cycle of inputs, update the model, queue the expectation.
    task automatic cyc(input bit rst, input logic mode, input logic ld,
                       input logic [15:0] seed, input logic en, input string tag);
        exp_t e;
        rst_n      = !rst;
        xnor_mode  = mode;
        seed_load  = ld;
        seed_value = seed;
        step_en    = en;
        if (rst) begin
            mdl_st = rec_of(mode); mdl_seen = 1'b0;
        end else if (ld) begin
            if (seed == bad_of(mode)) begin mdl_st = rec_of(mode); mdl_seen = 1'b1; end
            else mdl_st = seed;
        end else if (en) begin
            if (mdl_st == bad_of(mode)) begin mdl_st = rec_of(mode); mdl_seen = 1'b1; end
            else mdl_st = ref_step(mdl_st, mode, 16'h002D);
        end
        e.st = mdl_st; e.seen = mdl_seen; e.lock = (mdl_st == bad_of(mode)); e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare the main instance 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            check(state_out === e.st && lockup_now === e.lock && lockup_seen === e.seen,
                  e.tag, {14'd0, lockup_seen, lockup_now, state_out},
                  {14'd0, e.seen, e.lock, e.st});
            check(pn_bit === e.st[0], "R3 pn_bit", {31'd0, pn_bit}, {31'd0, e.st[0]});
        end
    end

    // Watchdog.
    initial begin
        #(4 * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] ra, rm;
        int p_main, p_alt, p_mir, bad_alt, bad_mir;
        @(negedge clk);
        // R1: reset in XOR mode.
        cyc(1, 0, 0, 16'h0, 0, "R1 reset XOR");
        cyc(1, 0, 0, 16'h0, 0, "R1 reset XOR");
        // R6: load beats step.
        cyc(0, 0, 1, 16'hACE1, 1, "R6 seed load priority");
        xs[0] = 16'hACE1;
        for (int k = 1; k <= 20; k++) begin
            cyc(0, 0, 0, 16'h0, 1, "R2 XOR step");
            xs[k] = mdl_st;
        end
        // R5: hold while the seed input changes.
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 16'h1234 + 16'(k), 0, "R5 hold");
        // R4: complement of the seed in XNOR mode.
        cyc(0, 1, 1, ~16'hACE1, 0, "R6 seed load XNOR");
        check(state_out === ~xs[0], "R4 complement seed", {16'd0, state_out}, {16'd0, ~xs[0]});
        for (int k = 1; k <= 20; k++) begin
            cyc(0, 1, 0, 16'h0, 1, "R4 XNOR step");
            check(state_out === ~xs[k], "R4 complement sequence",
                  {16'd0, state_out}, {16'd0, ~xs[k]});
        end
        // R7: forbidden seed in XNOR mode, then the flag stays up.
        cyc(0, 1, 1, 16'hFFFF, 0, "R7 XNOR forbidden seed");
        cyc(0, 1, 0, 16'h0, 1, "R7 sticky");
        // R1: reset in XNOR mode; R8: XOR view of zero; R9: recover.
        cyc(1, 1, 0, 16'h0, 0, "R1 reset XNOR");
        cyc(0, 0, 0, 16'h0, 0, "R8 zero forbidden in XOR");
        cyc(0, 0, 0, 16'h0, 1, "R9 XOR step recovers");
        // R4: XNOR runs from zero without a seed.
        cyc(1, 1, 0, 16'h0, 0, "R1 reset XNOR");
        for (int k = 0; k < 5; k++) cyc(0, 1, 0, 16'h0, 1, "R4 XNOR from zero");
        // R7: forbidden seed in XOR mode.
        cyc(1, 0, 0, 16'h0, 0, "R1 reset XOR");
        cyc(0, 0, 1, 16'h0000, 0, "R7 XOR forbidden seed");
        // All ones is legal in XOR, forbidden in XNOR.
        cyc(1, 0, 0, 16'h0, 0, "R1 reset XOR");
        cyc(0, 0, 1, 16'hFFFF, 0, "R6 all ones legal in XOR");
        cyc(0, 1, 0, 16'h0, 0, "R8 all ones forbidden in XNOR");
        cyc(0, 1, 0, 16'h0, 1, "R9 XNOR step recovers");
        // R10, R11, R12: periods from seed 0x8001, all three instances together.
        cyc(1, 0, 0, 16'h0, 0, "R1 reset XOR");
        cyc(0, 0, 1, 16'h8001, 0, "R6 period seed");
        ra = 16'h8001; rm = 16'h8001;
        p_main = 0; p_alt = 0; p_mir = 0; bad_alt = 0; bad_mir = 0;
        for (int n = 1; n <= 65600; n++) begin
            cyc(0, 0, 0, 16'h0, 1, "R2 period walk");
            ra = ref_step(ra, 1'b0, 16'h100B);
            rm = ref_step(rm, 1'b0, 16'h6801);
            if (a_state !== ra) bad_alt++;
            if (m_state !== rm) bad_mir++;
            if (p_main == 0 && state_out == 16'h8001) p_main = n;
            if (p_alt == 0 && a_state == 16'h8001) p_alt = n;
            if (p_mir == 0 && m_state == 16'h8001) p_mir = n;
            if (p_main != 0 && p_alt != 0 && p_mir != 0) break;
        end
        check(p_main == 65535, "R10 default period", p_main, 65535);
        check(p_alt == 65535, "R11 alternate period", p_alt, 65535);
        check(bad_alt == 0, "R11 alternate sequence", bad_alt, 0);
        check(p_mir == 65535, "R12 mirrored period", p_mir, 65535);
        check(bad_mir == 0, "R12 mirrored sequence", bad_mir, 0);
        @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule